// File: doc/BRIEF.md
# External Memory Word Packing Bridge

The bridge links one internal requester to an asynchronous external memory port with a 20-bit address bus and a 16-bit data bus. The data bus can run at its full width or at 8 bits. The requester asks for a 16-bit or a 24-bit logical word. The bridge turns that request into as many external bus cycles as the bus width requires. On a read it assembles the returned bytes or halfwords into one word. On a write it splits the word into bus-sized pieces.

Each external bus cycle has three parts. First comes one setup clock with the address valid and chip select low. Then a strobe window of fixed, parameter-set length. Last comes one hold clock with the address unchanged. The pieces go out least significant first, at consecutive external addresses that start from the requested one. The requester pulses a request. It gets a single-clock acknowledge after the last bus cycle, and read data is valid with that acknowledge. A request that arrives while an access is still running is dropped.

Top module: `xmem_pack_bridge`

## Requirements
- R1: After reset, chip select, read strobe and write strobe are high (inactive), and ack, busy and the data output enable are low.
- R2: The number of bus cycles per access is 2 (`wide`=0) or 3 (`wide`=1) when `bus16`=0, and 1 (`wide`=0) or 2 (`wide`=1) when `bus16`=1. An access accepted at a clock edge raises ack exactly beats*(STRB_CLKS+2) edges later.
- R3: Bus cycle k of an access drives `xa` = `addr`+k (modulo 2^20), least significant piece first.
- R4: Write pieces go out as follows. When `bus16`=0, cycle k drives byte k of `wdata` on `xd_out[7:0]` with `xd_out[15:8]`=0. When `bus16`=1, cycle 0 drives `wdata[15:0]` and cycle 1 (24-bit only) drives `wdata[23:16]` on the low lane with the upper lane 0. `wdata[23:16]` is never driven for a 16-bit word.
- R5: Read data is assembled as follows. When `bus16`=0, byte k of `rdata` comes from `xd_in[7:0]` of cycle k. When `bus16`=1, `rdata[15:0]` comes from cycle 0 and `rdata[23:16]` from `xd_in[7:0]` of cycle 1. Unused upper lanes of `xd_in` are ignored, and unfilled bits of `rdata` read 0.
- R6: Each bus cycle has one setup clock with `xcs_n` low and both strobes high, then exactly STRB_CLKS clocks with only the matching strobe low, then one hold clock. `xa` is stable across the whole cycle, and the two strobes are never low together.
- R7: `ack` is high for exactly one clock, with `busy` low and `xcs_n` high, and `rdata` is valid in that clock.
- R8: A request raised while `busy` is high is ignored. The running access completes unchanged, and no further bus activity follows it.
- R9: `xd_oe` is high only during write accesses, while `xcs_n` is low and `xrd_n` is high. It is high at every write strobe.

Ports of the top module, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request pulse; accepted when busy is low |
| we | input | 1 | 1 = write, 0 = read |
| wide | input | 1 | 1 = 24-bit word, 0 = 16-bit word |
| bus16 | input | 1 | 1 = 16-bit external bus, 0 = 8-bit |
| addr | input | ADDR_W | External start address |
| wdata | input | 3*LANE_W | Write word |
| ack | output | 1 | One-clock completion pulse |
| busy | output | 1 | Access in progress |
| rdata | output | 3*LANE_W | Assembled read word, valid with ack |
| xa | output | ADDR_W | External address |
| xd_out | output | 2*LANE_W | External write data |
| xd_in | input | 2*LANE_W | External read data |
| xd_oe | output | 1 | Drive enable for external data |
| xcs_n | output | 1 | Chip select, active low |
| xrd_n | output | 1 | Read strobe, active low |
| xwr_n | output | 1 | Write strobe, active low |

## Verification
All four width combinations are exercised, each for reads and for writes. Each combination yields a different beat count, address run and lane layout, so a wrong beat count or a wrong lane mapping shows up in only some of the combinations. Reads are served while the unused upper bus lane carries random junk, which tells real lane selection apart from passing the whole bus through. Start addresses at the 8-bit and 20-bit boundaries expose carry errors in the address counter. A request poked in mid-access separates a bridge that really drops it from one that restarts or queues a second access.

// File: rtl/xmp_pkg.sv
// Package for the external memory packing bridge.
// Holds the bus-cycle phase type and the beat-count rule, shared by all modules.
package xmp_pkg;

    // Phase of one external bus cycle
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } xmp_phase_e;

    // Number of external bus cycles for one logical word
    function automatic logic [1:0] xmp_beats(input logic bus16, input logic wide);
        if (bus16) return wide ? 2'd2 : 2'd1;
        else       return wide ? 2'd3 : 2'd2;
    endfunction

endpackage

// File: rtl/xmp_beat_timer.sv
// Beat timer: steps each bus cycle through setup, strobe and hold.
// Assumes STRB_CLKS >= 1. 'start' is honoured only in PH_IDLE, and
// 'last_beat' must be valid during PH_HOLD.
module xmp_beat_timer
    import xmp_pkg::*;
#(
    parameter int STRB_CLKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       last_beat,
    output xmp_phase_e phase,
    output logic       strobe_end,
    output logic       beat_next,
    output logic       xfer_done
);
    localparam int CW = $clog2(STRB_CLKS + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(STRB_CLKS - 1);

    logic [CW-1:0] cnt_q;

    // Phase sequencer and strobe-length counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            case (phase)
                PH_IDLE:   if (start) phase <= PH_SETUP;
                PH_SETUP: begin
                    phase <= PH_STROBE;
                    cnt_q <= '0;
                end
                PH_STROBE: begin
                    if (cnt_q == CNT_LAST) phase <= PH_HOLD;
                    else                   cnt_q <= cnt_q + 1'b1;
                end
                PH_HOLD:   phase <= last_beat ? PH_IDLE : PH_SETUP;
                default:   phase <= PH_IDLE;
            endcase
        end
    end

    // Event decode for the neighbouring blocks
    always_comb begin
        strobe_end = (phase == PH_STROBE) && (cnt_q == CNT_LAST);
        beat_next  = (phase == PH_HOLD) && !last_beat;
        xfer_done  = (phase == PH_HOLD) && last_beat;
    end

endmodule

// File: rtl/xmp_addr_gen.sv
// Address generator: loads the start address, steps it by one at each
// beat boundary and tracks the beat index against the beat count.
// Assumes nbeats is held constant for the whole access.
module xmp_addr_gen #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              beat_next,
    input  logic [1:0]        nbeats,
    output logic [ADDR_W-1:0] xa,
    output logic [1:0]        beat_idx,
    output logic              last_beat
);
    // Address and beat index registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xa       <= '0;
            beat_idx <= '0;
        end else if (start) begin
            xa       <= start_addr;
            beat_idx <= '0;
        end else if (beat_next) begin
            xa       <= xa + 1'b1;
            beat_idx <= beat_idx + 1'b1;
        end
    end

    // Last-beat flag for the timer
    always_comb last_beat = (beat_idx == (nbeats - 2'd1));

endmodule

// File: rtl/xmp_lane_mux.sv
// Lane mux: picks the write piece for the current beat and captures read
// pieces into the lanes of the assembled word. A 24-bit word is three lanes
// of LANE_W bits, and the bus is two lanes wide. In 8-bit mode only the low
// bus lane carries data.
module xmp_lane_mux #(
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                bus16,
    input  logic [1:0]          beat_idx,
    input  logic [3*LANE_W-1:0] wdata,
    input  logic                capture,
    input  logic [2*LANE_W-1:0] xd_in,
    output logic [2*LANE_W-1:0] xd_out,
    output logic [3*LANE_W-1:0] rdata
);
    localparam int NLANE = 3;

    // Write piece for the beat in progress
    always_comb begin
        xd_out = '0;
        if (bus16) begin
            if (beat_idx == 2'd0) xd_out = wdata[2*LANE_W-1:0];
            else                  xd_out = {{LANE_W{1'b0}}, wdata[3*LANE_W-1:2*LANE_W]};
        end else begin
            case (beat_idx)
                2'd0:    xd_out = {{LANE_W{1'b0}}, wdata[LANE_W-1:0]};
                2'd1:    xd_out = {{LANE_W{1'b0}}, wdata[2*LANE_W-1:LANE_W]};
                2'd2:    xd_out = {{LANE_W{1'b0}}, wdata[3*LANE_W-1:2*LANE_W]};
                default: xd_out = '0;
            endcase
        end
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic             hit;
        logic [LANE_W-1:0] src;

        // Which beat and bus lane fill word lane g
        always_comb begin
            if (bus16) begin
                hit = (g < 2) ? (beat_idx == 2'd0) : (beat_idx == 2'd1);
                src = (g == 1) ? xd_in[2*LANE_W-1:LANE_W] : xd_in[LANE_W-1:0];
            end else begin
                hit = (beat_idx == 2'(g));
                src = xd_in[LANE_W-1:0];
            end
        end

        // Lane register: cleared at accept, loaded at the end of its strobe
        always_ff @(posedge clk) begin
            if (!rst_n || clear)     rdata[g*LANE_W +: LANE_W] <= '0;
            else if (capture && hit) rdata[g*LANE_W +: LANE_W] <= src;
        end
    end

endmodule

// File: rtl/xmem_pack_bridge.sv
// External memory word packing bridge (top). It accepts one request at a
// time from an internal requester, latches the command and runs the packed
// bus cycles. It pulses ack when the last cycle completes. The requester
// must keep the bus-width setting valid at the request. Requests seen while
// busy are dropped.
module xmem_pack_bridge
    import xmp_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int LANE_W    = 8,
    parameter int STRB_CLKS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                we,
    input  logic                wide,
    input  logic                bus16,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [3*LANE_W-1:0] wdata,
    output logic                ack,
    output logic                busy,
    output logic [3*LANE_W-1:0] rdata,
    output logic [ADDR_W-1:0]   xa,
    output logic [2*LANE_W-1:0] xd_out,
    input  logic [2*LANE_W-1:0] xd_in,
    output logic                xd_oe,
    output logic                xcs_n,
    output logic                xrd_n,
    output logic                xwr_n
);
    localparam int WORD_W = 3 * LANE_W;

    xmp_phase_e        phase;
    logic              accept, strobe_end, beat_next, xfer_done, last_beat;
    logic              we_q, bus16_q;
    logic [1:0]        nbeats_q, beat_idx;
    logic [WORD_W-1:0] wdata_q;

    // Accept only when no access is in progress
    always_comb accept = req && (phase == PH_IDLE);

    // Command latch for the access in progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q     <= 1'b0;
            bus16_q  <= 1'b0;
            nbeats_q <= 2'd1;
            wdata_q  <= '0;
        end else if (accept) begin
            we_q     <= we;
            bus16_q  <= bus16;
            nbeats_q <= xmp_beats(bus16, wide);
            wdata_q  <= wdata;
        end
    end

    // Completion pulse, one clock after the last hold
    always_ff @(posedge clk) begin
        if (!rst_n) ack <= 1'b0;
        else        ack <= xfer_done;
    end

    xmp_beat_timer #(.STRB_CLKS(STRB_CLKS)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .last_beat  (last_beat),
        .phase      (phase),
        .strobe_end (strobe_end),
        .beat_next  (beat_next),
        .xfer_done  (xfer_done)
    );

    xmp_addr_gen #(.ADDR_W(ADDR_W)) i_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .start_addr (addr),
        .beat_next  (beat_next),
        .nbeats     (nbeats_q),
        .xa         (xa),
        .beat_idx   (beat_idx),
        .last_beat  (last_beat)
    );

    xmp_lane_mux #(.LANE_W(LANE_W)) i_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .bus16    (bus16_q),
        .beat_idx (beat_idx),
        .wdata    (wdata_q),
        .capture  (strobe_end && !we_q),
        .xd_in    (xd_in),
        .xd_out   (xd_out),
        .rdata    (rdata)
    );

    // Bus control decode from the registered phase
    always_comb begin
        busy  = (phase != PH_IDLE);
        xcs_n = (phase == PH_IDLE);
        xrd_n = !((phase == PH_STROBE) && !we_q);
        xwr_n = !((phase == PH_STROBE) && we_q);
        xd_oe = we_q && (phase != PH_IDLE);
    end

endmodule

// File: rtl/xmp_checker.sv
// Protocol checker for the packing bridge, bound to the top module.
// Measures strobe windows and beats with counters rather than deep $past.
module xmp_checker #(
    parameter int ADDR_W    = 20,
    parameter int STRB_CLKS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              busy,
    input logic              ack,
    input logic [ADDR_W-1:0] xa,
    input logic              xd_oe,
    input logic              xcs_n,
    input logic              xrd_n,
    input logic              xwr_n
);
    logic       strb_lo;
    logic [7:0] low_cnt;
    logic [2:0] beats_seen;

    always_comb strb_lo = !xrd_n || !xwr_n;

    // Length of the current strobe window
    always_ff @(posedge clk) begin
        if (!rst_n)       low_cnt <= '0;
        else if (strb_lo) low_cnt <= low_cnt + 1'b1;
        else              low_cnt <= '0;
    end

    // Strobe starts since the last ack
    always_ff @(posedge clk) begin
        if (!rst_n || ack)               beats_seen <= '0;
        else if (strb_lo && low_cnt == 0) beats_seen <= beats_seen + 1'b1;
    end

    p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!xrd_n && !xwr_n));
    p_strobe_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strb_lo |-> !xcs_n);
    p_strobe_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_lo && low_cnt != 0) |-> (low_cnt == STRB_CLKS));
    p_addr_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strb_lo |-> $stable(xa));
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_lo && low_cnt != 0) |-> $stable(xa));
    p_beats_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (beats_seen >= 3'd1 && beats_seen <= 3'd3));
    p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    p_ack_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (!busy && xcs_n));
    p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xcs_n) |-> ($past(req) && !$past(busy)));
    p_oe_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xd_oe |-> (xrd_n && !xcs_n));

endmodule

bind xmem_pack_bridge xmp_checker #(.ADDR_W(ADDR_W), .STRB_CLKS(STRB_CLKS)) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .busy  (busy),
    .ack   (ack),
    .xa    (xa),
    .xd_oe (xd_oe),
    .xcs_n (xcs_n),
    .xrd_n (xrd_n),
    .xwr_n (xwr_n)
);

// File: tb/test_xmem_pack_bridge.sv
`timescale 1ns/1ps
module test_xmem_pack_bridge;
    localparam int STRB = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0, wide = 1'b0, bus16 = 1'b0;
    logic [19:0] addr = '0;
    logic [23:0] wdata = '0;
    logic        ack, busy, xd_oe, xcs_n, xrd_n, xwr_n;
    logic [23:0] rdata;
    logic [19:0] xa;
    logic [15:0] xd_out, xd_in;

    logic [15:0] mem [0:255];
    logic [7:0]  junk = 8'h00;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    xmem_pack_bridge #(.ADDR_W(20), .LANE_W(8), .STRB_CLKS(STRB)) i_xmem_pack_bridge (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .wide(wide), .bus16(bus16),
        .addr(addr), .wdata(wdata), .ack(ack), .busy(busy), .rdata(rdata),
        .xa(xa), .xd_out(xd_out), .xd_in(xd_in), .xd_oe(xd_oe),
        .xcs_n(xcs_n), .xrd_n(xrd_n), .xwr_n(xwr_n)
    );

    // External memory model; the unused upper lane carries junk in 8-bit mode
    always_comb xd_in = bus16 ? mem[xa[7:0]] : {junk, mem[xa[7:0]][7:0]};

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic int nbeats(input bit b16, input bit wd);
        return b16 ? (wd ? 2 : 1) : (wd ? 3 : 2);
    endfunction

    function automatic logic [15:0] exp_wbeat(input bit b16, input logic [23:0] d, input int k);
        if (b16) return (k == 0) ? d[15:0] : {8'h00, d[23:16]};
        return {8'h00, d[8*k +: 8]};
    endfunction

    function automatic logic [23:0] exp_rd(input bit b16, input bit wd, input logic [19:0] a);
        logic [23:0] r = '0;
        if (b16) begin
            r[15:0] = mem[a[7:0]];
            if (wd) r[23:16] = mem[8'(a + 1)][7:0];
        end else begin
            for (int k = 0; k < nbeats(b16, wd); k++) r[8*k +: 8] = mem[8'(a + k)][7:0];
        end
        return r;
    endfunction

    // One access: drive the request, watch the bus, check beats, data and ack
    task automatic run_access(input bit w, input bit wd, input bit b16,
                              input logic [19:0] a, input logic [23:0] d, input bit poke);
        logic [19:0] log_a [0:3];
        logic [15:0] log_d [0:3];
        int nb = 0, lat = 1, n = nbeats(b16, wd);
        bit prev_rd = 1, prev_wr = 1, prev_cs = 1, oe_bad = 0;
        @(negedge clk);
        req = 1; we = w; wide = wd; bus16 = b16; addr = a; wdata = d; junk = 8'($urandom);
        @(negedge clk);
        req = 0;
        while (!ack && lat < 200) begin
            if ((!xrd_n && prev_rd) || (!xwr_n && prev_wr)) begin
                chk(prev_cs == 0, "R6 setup clock before strobe", {31'd0, prev_cs}, 0);
                if (w) chk(xd_oe == 1, "R9 oe at write strobe", {31'd0, xd_oe}, 1);
                if (nb < 4) begin log_a[nb] = xa; log_d[nb] = xd_out; end
                nb++;
            end
            if (!w && xd_oe) oe_bad = 1;
            prev_rd = xrd_n; prev_wr = xwr_n; prev_cs = xcs_n;
            if (poke && lat == 3) begin req = 1; we = ~w; addr = a ^ 20'h5A5A5; end
            if (poke && lat == 4) req = 0;
            @(negedge clk);
            lat++;
        end
        chk(lat == n * (STRB + 2) + 1, "R2 ack latency", lat, n * (STRB + 2) + 1);
        chk(nb == n, "R2 bus cycle count", nb, n);
        for (int k = 0; k < n && k < nb && k < 4; k++) begin
            chk(log_a[k] == 20'(a + k), "R3 beat address", {12'd0, log_a[k]}, {12'd0, 20'(a + k)});
            if (w) chk(log_d[k] == exp_wbeat(b16, d, k), "R4 write piece",
                       {16'd0, log_d[k]}, {16'd0, exp_wbeat(b16, d, k)});
        end
        if (!w) begin
            chk(rdata == exp_rd(b16, wd, a), "R5 assembled read", {8'd0, rdata}, {8'd0, exp_rd(b16, wd, a)});
            chk(!oe_bad, "R9 oe low on read", {31'd0, oe_bad}, 0);
        end
        chk(!busy && xcs_n, "R7 idle with ack", {30'd0, busy, xcs_n}, 1);
        @(negedge clk);
        chk(ack == 0, "R7 ack single clock", {31'd0, ack}, 0);
        if (poke) begin
            for (int i = 0; i < 6; i++) begin
                chk(xcs_n && !busy, "R8 request while busy ignored", {30'd0, xcs_n, busy}, 2);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
        repeat (4) @(negedge clk);
        chk(xcs_n && xrd_n && xwr_n, "R1 strobes idle in reset", {29'd0, xcs_n, xrd_n, xwr_n}, 7);
        chk(!ack && !busy && !xd_oe, "R1 status idle in reset", {29'd0, ack, busy, xd_oe}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(xcs_n && xrd_n && xwr_n && !ack && !busy && !xd_oe, "R1 idle after reset",
            {26'd0, xcs_n, xrd_n, xwr_n, ack, busy, xd_oe}, 6'b111000);
        // Directed: every width combination, reads and writes
        for (int c = 0; c < 4; c++) begin
            run_access(1, c[0], c[1], 20'h00010, 24'hA5C37E, 0);
            run_access(0, c[0], c[1], 20'h00020, 24'h0, 0);
        end
        // Boundary addresses
        run_access(0, 1, 0, 20'h000FF, 24'h0, 0);
        run_access(1, 1, 0, 20'hFFFFF, 24'h123456, 0);
        run_access(0, 1, 1, 20'hFFFFF, 24'h0, 0);
        // Request while busy
        run_access(1, 1, 0, 20'h00400, 24'hC0FFEE, 1);
        run_access(0, 0, 1, 20'h00500, 24'h0, 1);
        // Constrained random
        for (int i = 0; i < 60; i++)
            run_access($urandom_range(1), $urandom_range(1), $urandom_range(1),
                       20'($urandom), 24'($urandom), ($urandom_range(7) == 0));
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule